// File: doc/BRIEF.md
# SPI Slave Port with Selectable Select Source

This block is an 8-bit SPI slave that sits on a CPU register bus. The CPU writes a byte into a transmit holding register, and reads each byte received from the external master out of a receive holding register. Two status flags pace the exchange. One shows that the transmit holding register can take another byte. The other shows that an unread received byte is waiting. The serial clock, the data input and every candidate select input are brought into the system clock domain through a flip-flop chain. The serial edges are then found from the synchronized clock. The bus uses clock-polarity-0, clock-phase-0 timing with the most significant bit first.

The active-low select that frames a transfer comes from a configuration register. In normal use a two-bit field picks one of four external select inputs. When the force bit is set, the select follows bit 0 of that same field instead, so software can open and close a transfer by itself without a spare pin. An interrupt output either stays high while the transmit holding register is free, or gives a single-cycle pulse for each byte completed. The configuration chooses between the two.

Top module: `spi_target_port`

## Requirements
- R1: After reset the status register reads 0x01, the configuration register reads 0x00, the interrupt output is high, MISO is 1 and the MISO output enable is 0.
- R2: Register addresses: 0 is the write-only transmit holding register and reads 0. 1 is the read-only receive holding register. 2 is configuration: bit 0 selects the interrupt type, bit 1 forces the select, bits 3:2 are the select field, and the upper bits read 0. 3 is the read-only status register: bit 0 shows transmit empty, bit 1 shows receive full, and the other bits read 0.
- R3: A write to address 0 clears transmit empty. Transmit empty is set again when that byte moves into the shift register, on a falling select edge or at a byte boundary.
- R4: Data is sampled on rising SCLK edges, MSB first. After the eighth rising edge the byte goes to the receive holding register and receive full is set. A bus read of address 1 clears receive full.
- R5: MISO shows the loaded byte MSB first and changes only after a falling SCLK edge. While the select is high, MISO shows the MSB of the pending transmit byte.
- R6: If no transmit byte is pending when a byte starts, the slave sends 0xFF.
- R7: With the force bit at 0, the select is the external select input picked by the select field. The other select inputs have no effect.
- R8: With the force bit at 1, the select equals bit 2 of the configuration register, and all external select inputs are ignored.
- R9: If the select rises before the eighth bit, the partial byte is dropped. The receive holding register and receive full stay unchanged, and the next transfer starts at bit 7.
- R10: With interrupt type 0, the interrupt output equals transmit empty. With type 1, it pulses high for one cycle for each completed byte.
- R11: If a byte is waiting at a byte boundary while the select stays low, it is loaded on the next falling SCLK edge, so bytes can follow each other without gaps.
- R12: The MISO output enable is high only while the selected select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sclk_in | input | 1 | Serial clock from the master |
| mosi_in | input | 1 | Serial data from the master |
| ss_n_in | input | 4 | Candidate active-low select inputs |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for MISO |
| irq_out | output | 1 | Interrupt request |

## Verification
A wrong bit count or a wrong shift register shows up at once in the byte the master reads on MISO. It also shows in the receive holding register three system clocks after the eighth rising SCLK edge. A stuck flag shows in the status register and, through the interrupt, in the very next bus cycle after the write, read or load that should have moved it. A wrong select source shows in the output enable within the synchronizer delay of the chosen input changing. Ignored inputs are checked by driving them low and watching the output enable and the transmit-empty flag stay put.

// File: rtl/spit_pkg.sv
package spit_pkg;
  typedef enum logic [1:0] {
    REG_TXB  = 2'd0,
    REG_RXB  = 2'd1,
    REG_CFG  = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam int CFG_IRQ_BIT   = 0;
  localparam int CFG_FORCE_BIT = 1;
  localparam int CFG_SEL_LSB   = 2;
  localparam int STAT_TXE_BIT  = 0;
  localparam int STAT_RXF_BIT  = 1;
endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spit_ss_sel.sv
module spit_ss_sel #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] ss_n_src,
  input  logic             force_en,
  input  logic [SEL_W-1:0] sel,
  output logic             ss_n
);
  logic mux_n;

  always_comb begin
    mux_n = 1'b1;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) mux_n = ss_n_src[i];
    end
  end

  assign ss_n = force_en ? sel[0] : mux_n;
endmodule

// File: rtl/spit_shifter.sv
module spit_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              take,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso
);
  localparam int                CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);
  localparam int                MSB   = DATA_W - 1;

  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              smp_q, smp_n;
  logic              reload_q, reload_n;
  logic              ss_prev_q;
  logic              ss_fall;
  logic [DATA_W-1:0] fill;

  assign ss_fall = ss_prev_q & ~ss_n;
  assign fill    = tx_valid ? tx_data : {DATA_W{1'b1}};

  always_comb begin
    sh_n     = sh_q;
    cnt_n    = cnt_q;
    smp_n    = smp_q;
    reload_n = reload_q;
    take     = 1'b0;
    done     = 1'b0;
    if (ss_n) begin
      cnt_n    = '0;
      reload_n = 1'b0;
    end else if (ss_fall) begin
      take     = tx_valid;
      sh_n     = fill;
      cnt_n    = '0;
      reload_n = 1'b0;
    end else begin
      if (sclk_rise) begin
        smp_n = mosi;
        if (cnt_q == LAST) begin
          done     = 1'b1;
          cnt_n    = '0;
          reload_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (sclk_fall) begin
        if (reload_q) begin
          take     = tx_valid;
          sh_n     = fill;
          reload_n = 1'b0;
        end else begin
          sh_n = {sh_q[MSB-1:0], smp_q};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= {DATA_W{1'b1}};
      cnt_q     <= '0;
      smp_q     <= 1'b0;
      reload_q  <= 1'b0;
      ss_prev_q <= 1'b1;
    end else begin
      sh_q      <= sh_n;
      cnt_q     <= cnt_n;
      smp_q     <= smp_n;
      reload_q  <= reload_n;
      ss_prev_q <= ss_n;
    end
  end

  assign rx_byte = {sh_q[MSB-1:0], mosi};
  assign miso    = (ss_n | ss_prev_q) ? fill[MSB] : sh_q[MSB];
endmodule

// File: rtl/spit_regs.sv
module spit_regs
  import spit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              take,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              byte_pulse,
  output logic              irq_type,
  output logic              ss_force,
  output logic [SEL_W-1:0]  ss_sel
);
  localparam int CFG_W = CFG_SEL_LSB + SEL_W;

  logic [DATA_W-1:0] txb_q, txb_n, rxb_q, rxb_n;
  logic [CFG_W-1:0]  cfg_q, cfg_n;
  logic              txe_q, txe_n, rxf_q, rxf_n, pulse_q;
  logic              wr_tx, wr_cfg, rd_rx;

  assign wr_tx  = wr && (reg_addr_e'(addr) == REG_TXB);
  assign wr_cfg = wr && (reg_addr_e'(addr) == REG_CFG);
  assign rd_rx  = rd && (reg_addr_e'(addr) == REG_RXB);

  always_comb begin
    txb_n = txb_q;
    txe_n = txe_q;
    if (take) txe_n = 1'b1;
    if (wr_tx) begin
      txb_n = wdata;
      txe_n = 1'b0;
    end
    rxb_n = rxb_q;
    rxf_n = rxf_q;
    if (done) begin
      rxb_n = rx_byte;
      rxf_n = 1'b1;
    end else if (rd_rx) begin
      rxf_n = 1'b0;
    end
    cfg_n = cfg_q;
    if (wr_cfg) cfg_n = wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q   <= '0;
      txe_q   <= 1'b1;
      rxb_q   <= '0;
      rxf_q   <= 1'b0;
      cfg_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      txb_q   <= txb_n;
      txe_q   <= txe_n;
      rxb_q   <= rxb_n;
      rxf_q   <= rxf_n;
      cfg_q   <= cfg_n;
      pulse_q <= done;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      REG_RXB:  rdata = rxb_q;
      REG_CFG:  rdata = DATA_W'(cfg_q);
      REG_STAT: begin
        rdata[STAT_TXE_BIT] = txe_q;
        rdata[STAT_RXF_BIT] = rxf_q;
      end
      default:  rdata = '0;
    endcase
  end

  assign tx_data    = txb_q;
  assign tx_empty   = txe_q;
  assign rx_full    = rxf_q;
  assign byte_pulse = pulse_q;
  assign irq_type   = cfg_q[CFG_IRQ_BIT];
  assign ss_force   = cfg_q[CFG_FORCE_BIT];
  assign ss_sel     = cfg_q[CFG_SEL_LSB +: SEL_W];
endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spit_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int N_SS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk_in,
  input  logic              mosi_in,
  input  logic [N_SS-1:0]   ss_n_in,
  output logic              miso_out,
  output logic              miso_oe,
  output logic              irq_out
);
  localparam int             SEL_W   = (N_SS > 2) ? $clog2(N_SS) : 1;
  localparam int             SYNC_W  = N_SS + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{N_SS{1'b1}}, 2'b00};

  logic [1:0]        rst_pipe_q;
  logic              rst_n_sync;
  logic [SYNC_W-1:0] sync_q;
  logic              sclk_s, mosi_s, sclk_prev_q;
  logic              sclk_rise, sclk_fall;
  logic [N_SS-1:0]   ss_s;
  logic              ss_sel_n;
  logic              sh_take, sh_done;
  logic [DATA_W-1:0] rx_byte, tx_data;
  logic              tx_empty, rx_full, byte_pulse;
  logic              cfg_irq_type, cfg_force;
  logic [SEL_W-1:0]  cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  spit_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n_sync),
    .d({ss_n_in, mosi_in, sclk_in}), .q(sync_q)
  );
  assign sclk_s = sync_q[0];
  assign mosi_s = sync_q[1];
  assign ss_s   = sync_q[SYNC_W-1:2];

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) sclk_prev_q <= 1'b0;
    else             sclk_prev_q <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;

  spit_ss_sel #(.N_SRC(N_SS), .SEL_W(SEL_W)) u_ss_sel (
    .ss_n_src(ss_s), .force_en(cfg_force), .sel(cfg_sel), .ss_n(ss_sel_n)
  );

  spit_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n_sync), .ss_n(ss_sel_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_s),
    .tx_valid(~tx_empty), .tx_data(tx_data),
    .take(sh_take), .done(sh_done), .rx_byte(rx_byte), .miso(miso_out)
  );

  spit_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .take(sh_take), .done(sh_done), .rx_byte(rx_byte),
    .tx_data(tx_data), .tx_empty(tx_empty), .rx_full(rx_full), .byte_pulse(byte_pulse),
    .irq_type(cfg_irq_type), .ss_force(cfg_force), .ss_sel(cfg_sel)
  );

  assign miso_oe = ~ss_sel_n;
  assign irq_out = cfg_irq_type ? byte_pulse : tx_empty;
endmodule

// File: rtl/spit_checker.sv
module spit_checker
  import spit_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic       rd,
  input logic [1:0] addr,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       take,
  input logic       done,
  input logic       ss_n,
  input logic       sclk_fall,
  input logic       miso,
  input logic       irq,
  input logic       irq_type
);
  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_TXB) |=> !tx_empty); // R3

  AST_EMPTY_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(take)); // R3

  AST_FULL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(done)); // R4

  AST_RD_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == REG_RXB && !done) |=> !rx_full); // R4

  AST_MISO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && $past(!ss_n) && !$past(sclk_fall)) |-> $stable(miso)); // R5

  AST_PULSE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_type && irq) |-> rx_full); // R10
endmodule

bind spi_target_port spit_checker u_chk (
  .clk(clk), .rst_n(rst_n_sync), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
  .tx_empty(tx_empty), .rx_full(rx_full), .take(sh_take), .done(sh_done),
  .ss_n(ss_sel_n), .sclk_fall(sclk_fall), .miso(miso_out), .irq(irq_out),
  .irq_type(cfg_irq_type)
);

// File: tb/test_spi_target_port.sv
module test_spi_target_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk_in = 1'b0, mosi_in = 1'b0;
  logic [3:0] ss_n_in = 4'hF;
  logic       miso_out, miso_oe, irq_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  int  irq_cnt  = 0;
  bit  irq_cnt_en = 1'b0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  spi_target_port i_spi_target_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_in(sclk_in), .mosi_in(mosi_in), .ss_n_in(ss_n_in),
    .miso_out(miso_out), .miso_oe(miso_oe), .irq_out(irq_out)
  );

  always @(posedge clk) if (irq_cnt_en && irq_out) irq_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic spi_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi_in = mo[i];
      wait_clk(8);
      mi[i] = miso_out;
      sclk_in = 1'b1;
      wait_clk(8);
      sclk_in = 1'b0;
    end
    wait_clk(6);
  endtask

  task automatic select_low(input logic [3:0] v);
    ss_n_in = v;
    wait_clk(6);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(2'd3, d); expect_eq("R1 status after reset", d, 8'h01);
    peek(2'd2, d); expect_eq("R1 config after reset", d, 8'h00);
    expect_eq("R1 irq after reset", irq_out, 1);
    expect_eq("R1 miso after reset", miso_out, 1);
    expect_eq("R1 miso_oe after reset", miso_oe, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    bus_write(2'd2, 8'hFD);
    peek(2'd2, d); expect_eq("R2 config readback upper bits zero", d, 8'h0D);
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'hFF);
    peek(2'd3, d); expect_eq("R2 status not writable", d, 8'h01);
    bus_write(2'd1, 8'h55);
    peek(2'd1, d); expect_eq("R2 rx buffer not writable", d, 8'h00);
    bus_write(2'd0, 8'hA5);
    peek(2'd0, d); expect_eq("R2 tx buffer reads zero", d, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] d, mi;
    peek(2'd3, d); expect_eq("R3 write clears tx empty", d, 8'h00);
    expect_eq("R10 type0 irq low while tx full", irq_out, 0);
    expect_eq("R5 miso shows pending msb while idle", miso_out, 1);
    select_low(4'b1110);
    peek(2'd3, d); expect_eq("R3 tx empty set on load at select fall", d, 8'h01);
    expect_eq("R12 miso_oe while selected", miso_oe, 1);
    expect_eq("R10 type0 irq follows tx empty", irq_out, 1);
    spi_bits(8'h3C, 8, mi);
    expect_eq("R5 miso byte msb first", mi, 8'hA5);
    peek(2'd3, d); expect_eq("R4 rx full after byte", d, 8'h03);
    bus_read(2'd1, d); expect_eq("R4 rx data msb first", d, 8'h3C);
    peek(2'd3, d); expect_eq("R4 read clears rx full", d, 8'h01);
    select_low(4'hF);
    expect_eq("R12 miso_oe off when deselected", miso_oe, 0);
  endtask

  task automatic t_fill;
    logic [7:0] d, mi;
    select_low(4'b1110);
    spi_bits(8'h00, 8, mi);
    expect_eq("R6 idle fill byte", mi, 8'hFF);
    bus_read(2'd1, d); expect_eq("R6 rx with fill", d, 8'h00);
    select_low(4'hF);
  endtask

  task automatic t_b2b;
    logic [7:0] d, mi;
    bus_write(2'd0, 8'h11);
    select_low(4'b1110);
    bus_write(2'd0, 8'h22);
    spi_bits(8'h81, 8, mi);
    expect_eq("R11 first byte out", mi, 8'h11);
    peek(2'd3, d); expect_eq("R11 second byte taken at boundary", d, 8'h03);
    spi_bits(8'h7E, 8, mi);
    expect_eq("R11 second byte out without gap", mi, 8'h22);
    bus_read(2'd1, d); expect_eq("R11 second byte received", d, 8'h7E);
    select_low(4'hF);
  endtask

  task automatic t_mux;
    logic [7:0] d, mi;
    bus_write(2'd2, 8'h08);
    bus_write(2'd0, 8'h5A);
    select_low(4'b1110);
    expect_eq("R7 unselected input ignored oe", miso_oe, 0);
    peek(2'd3, d); expect_eq("R7 unselected input causes no load", d, 8'h00);
    select_low(4'b1011);
    expect_eq("R7 selected input drives oe", miso_oe, 1);
    spi_bits(8'hE1, 8, mi);
    expect_eq("R7 byte through input 2", mi, 8'h5A);
    bus_read(2'd1, d); expect_eq("R7 rx through input 2", d, 8'hE1);
    select_low(4'hF);
  endtask

  task automatic t_force;
    logic [7:0] d, mi;
    ss_n_in = 4'h0;
    bus_write(2'd2, 8'h06);
    wait_clk(6);
    expect_eq("R8 forced high ignores inputs", miso_oe, 0);
    bus_write(2'd2, 8'h02);
    wait_clk(4);
    expect_eq("R8 forced low selects", miso_oe, 1);
    spi_bits(8'h96, 8, mi);
    bus_read(2'd1, d); expect_eq("R8 rx under forced select", d, 8'h96);
    bus_write(2'd2, 8'h06);
    wait_clk(4);
    expect_eq("R8 forced high again", miso_oe, 0);
    ss_n_in = 4'hF;
    bus_write(2'd2, 8'h00);
    wait_clk(6);
  endtask

  task automatic t_partial;
    logic [7:0] d, mi;
    select_low(4'b1110);
    spi_bits(8'hF0, 4, mi);
    select_low(4'hF);
    peek(2'd3, d); expect_eq("R9 partial byte does not set rx full", d, 8'h01);
    peek(2'd1, d); expect_eq("R9 rx buffer unchanged", d, 8'hE1 ^ 8'hE1 ^ 8'h96);
    select_low(4'b1110);
    spi_bits(8'hC3, 8, mi);
    bus_read(2'd1, d); expect_eq("R9 next byte aligned", d, 8'hC3);
    select_low(4'hF);
  endtask

  task automatic t_pulse;
    logic [7:0] d, mi;
    bus_write(2'd2, 8'h01);
    wait_clk(1);
    expect_eq("R10 type1 irq idle low", irq_out, 0);
    irq_cnt = 0;
    irq_cnt_en = 1'b1;
    select_low(4'b1110);
    spi_bits(8'h4B, 8, mi);
    irq_cnt_en = 1'b0;
    expect_eq("R10 type1 one pulse per byte", irq_cnt, 1);
    bus_read(2'd1, d); expect_eq("R10 byte with pulse", d, 8'h4B);
    select_low(4'hF);
    bus_write(2'd2, 8'h00);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset;
    t_regs;
    t_basic;
    t_fill;
    t_b2b;
    t_mux;
    t_force;
    t_partial;
    t_pulse;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired before the scenarios ended");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule